// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block sits on the host side of an 8-bit parallel NAND flash bus and carries out one page program per request. A request names the target row, the first column and the number of bytes. The bytes then arrive on a stream. For each transaction the block drives a setup command, the column and row address bytes, the data bytes and a confirm command. It then waits for the device to report ready and reads back the status byte. A single pulse reports the result.

A data beat may carry a jump flag and a new column. When a beat carries the flag, the block first sends a random-data-input command and two column bytes, and only then writes that beat's byte. This lets one transaction scatter data across a page. The block tracks how many times each page has been programmed and refuses any request beyond the partial-program limit without touching the bus. A busy period longer than a set bound ends the transaction with a timeout pulse.

Both streams use valid/ready handshakes. A request is taken only while the block is idle. A data beat is taken only in the cycle that starts its bus write, and the bytes are never buffered. While the block waits, a producer holds `din_valid` and its payload steady. The producer may drop valid between beats at any time.

Top module: `nand_pgm_seq`

## Requirements
- R1: While reset is held and right after it, chip enable, write strobe and read strobe are high, both latch enables are low, `req_ready` is high and `done_o`, `limit_err_o` and `timeout_err_o` are low.
- R2: A transaction drives the following bus cycles in order: command 0x80 with the command latch high, `ADDR_CYC` address cycles with the address latch high, one data cycle per byte with both latches low, command 0x10, and finally command 0x70. A bus cycle is recorded when the write strobe rises.
- R3: The address cycles carry the column low byte, then the column high byte, then the row bytes starting from the least significant.
- R4: A data beat that has `din_jump` set is preceded by command 0x85 and two address cycles holding `din_col`, low byte first. The beat's byte is written after them and the following bytes continue in the stream.
- R5: Every write or read strobe stays low for exactly `STROBE_W` clocks. The data bus stays unchanged while the write strobe is low.
- R6: `din_ready` is high only while `din_valid` is high. `req_ready` is high only while chip enable is high.
- R7: After the confirm command, `done_o` pulses for one cycle only after `nand_rb` has risen and the status byte has been read. `fail_o` equals bit 0 of that byte.
- R8: If `nand_rb` stays low for `TIMEOUT` clocks after the settle gap, `timeout_err_o` pulses, no status command is issued, `done_o` does not pulse and the block returns to idle.
- R9: The fifth program request to the same row pulses `limit_err_o` without asserting chip enable or any strobe. A request to a different row is still served afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted (idle) |
| req_row | input | ROW_W | Page row address |
| req_col | input | 16 | Starting column |
| req_len | input | 16 | Byte count, at least 1 |
| din_valid | input | 1 | Data beat offered |
| din_ready | output | 1 | Data beat taken |
| din_byte | input | 8 | Data byte |
| din_jump | input | 1 | Jump to din_col before this byte |
| din_col | input | 16 | Jump column |
| nand_io_out | output | 8 | Bus byte driven |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | 8 | Bus byte read |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb | input | 1 | Ready (high) / busy (low) |
| done_o | output | 1 | Transaction finished pulse |
| fail_o | output | 1 | Status fail flag, valid with done_o |
| limit_err_o | output | 1 | Partial-program limit reached pulse |
| timeout_err_o | output | 1 | Busy timeout pulse |

## Verification
The bench builds the block with four address cycles, a strobe width of 2, a settle gap of 2, a busy limit of 40 clocks and an 8-slot page tally. The short busy limit lets a device that stays busy for 300 clocks trigger a timeout in a short run. The small tally lets rows be picked so that their slots are known to be distinct. With a strobe width of 2, each low phase spans several clocks, so a strobe that is cut short or a data bus that changes mid-strobe shows up in the low-run measurement.

// File: rtl/nand_pgm_pkg.sv
package nand_pgm_pkg;
  typedef enum logic [1:0] {CK_CMD, CK_ADDR, CK_DATA, CK_READ} cyc_kind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_SETUP, S_ADDR, S_DATA, S_JCMD, S_JADDR,
    S_CONF, S_GAP, S_WAIT, S_SCMD, S_SRD
  } seq_state_t;

  localparam logic [7:0] OP_LOAD    = 8'h80;
  localparam logic [7:0] OP_JUMP    = 8'h85;
  localparam logic [7:0] OP_COMMIT  = 8'h10;
  localparam logic [7:0] OP_STATUS  = 8'h70;
endpackage

// File: rtl/nand_bus_strobe.sv
module nand_bus_strobe
  import nand_pgm_pkg::*;
#(
  parameter int unsigned HOLD = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  cyc_kind_t kind_i,
  input  logic [7:0] byte_i,
  input  logic [7:0] io_in,
  output logic      done,
  output logic [7:0] rd_byte,
  output logic      we_n,
  output logic      re_n,
  output logic      cle,
  output logic      ale,
  output logic [7:0] io_out,
  output logic      io_oe
);
  localparam int unsigned SPAN = 2 * HOLD;
  localparam int unsigned CW   = (SPAN > 1) ? $clog2(SPAN) : 1;

  logic           active_q;
  logic [CW-1:0]  cnt_q;
  cyc_kind_t      kind_q;
  logic [7:0]     byte_q;
  logic           low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      kind_q   <= CK_CMD;
      byte_q   <= 8'h00;
      rd_byte  <= 8'h00;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      kind_q   <= kind_i;
      byte_q   <= byte_i;
    end else if (active_q) begin
      if (cnt_q == CW'(SPAN - 1)) active_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
      if (kind_q == CK_READ && cnt_q == CW'(HOLD - 1)) rd_byte <= io_in;
    end
  end

  assign low    = active_q && (cnt_q < CW'(HOLD));
  assign we_n   = !(low && kind_q != CK_READ);
  assign re_n   = !(low && kind_q == CK_READ);
  assign cle    = active_q && kind_q == CK_CMD;
  assign ale    = active_q && kind_q == CK_ADDR;
  assign io_oe  = active_q && kind_q != CK_READ;
  assign io_out = io_oe ? byte_q : 8'h00;
  assign done   = active_q && cnt_q == CW'(SPAN - 1);

  // R5
  bus_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(io_out));

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active_q);
endmodule

// File: rtl/nand_page_tally.sv
module nand_page_tally #(
  parameter int unsigned ROW_W = 16,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] row,
  output logic             allow,
  input  logic             bump
);
  localparam int unsigned SLOTS = 1 << IDX_W;
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  logic [SLOTS-1:0] vld_q;
  logic [ROW_W-1:0] tag_q [SLOTS];
  logic [CW-1:0]    cnt_q [SLOTS];
  logic [IDX_W-1:0] idx;
  logic             hit;

  assign idx   = row[IDX_W-1:0];
  assign hit   = vld_q[idx] && tag_q[idx] == row;
  assign allow = !hit || cnt_q[idx] < CW'(LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int s = 0; s < int'(SLOTS); s++) begin
        tag_q[s] <= '0;
        cnt_q[s] <= '0;
      end
    end else if (bump) begin
      vld_q[idx] <= 1'b1;
      tag_q[idx] <= row;
      cnt_q[idx] <= hit ? cnt_q[idx] + 1'b1 : CW'(1);
    end
  end

  for (genvar g = 0; g < int'(SLOTS); g++) begin : g_slot
    // R9
    tally_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] <= CW'(LIMIT));
  end
endmodule

// File: rtl/nand_pgm_seq.sv
module nand_pgm_seq
  import nand_pgm_pkg::*;
#(
  parameter int unsigned ADDR_CYC  = 5,
  parameter int unsigned STROBE_W  = 2,
  parameter int unsigned BUSY_GAP  = 2,
  parameter int unsigned TIMEOUT   = 4096,
  parameter int unsigned TALLY_IDX = 6,
  parameter int unsigned PP_LIMIT  = 4,
  localparam int unsigned ROW_W    = 8 * (ADDR_CYC - 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [15:0]      req_col,
  input  logic [15:0]      req_len,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic [7:0]       din_byte,
  input  logic             din_jump,
  input  logic [15:0]      din_col,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_in,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_ce_n,
  output logic             nand_we_n,
  output logic             nand_re_n,
  input  logic             nand_rb,
  output logic             done_o,
  output logic             fail_o,
  output logic             limit_err_o,
  output logic             timeout_err_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT + BUSY_GAP + 1);

  seq_state_t       state_q;
  logic             pend_q, jtaken_q;
  logic [2:0]       idx_q;
  logic [15:0]      col_q, left_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt_q;
  logic             go, cyc_done, allow;
  cyc_kind_t        kind;
  logic [7:0]       obyte, rd_byte;
  logic [ROW_W-1:0] row_sh;
  logic             want_jump;
  logic             unused_status;

  assign unused_status = ^rd_byte[7:1];
  assign req_ready     = state_q == S_IDLE;
  assign nand_ce_n     = state_q == S_IDLE || state_q == S_CHECK;
  assign want_jump     = din_jump && !jtaken_q;
  assign din_ready     = state_q == S_DATA && !pend_q && din_valid && !want_jump;
  assign row_sh        = row_q >> {idx_q - 3'd2, 3'b000};

  always_comb begin
    go    = 1'b0;
    kind  = CK_CMD;
    obyte = 8'h00;
    unique case (state_q)
      S_SETUP: begin go = !pend_q; obyte = OP_LOAD; end
      S_ADDR: begin
        go   = !pend_q;
        kind = CK_ADDR;
        if (idx_q == 3'd0)      obyte = col_q[7:0];
        else if (idx_q == 3'd1) obyte = col_q[15:8];
        else                    obyte = row_sh[7:0];
      end
      S_DATA:  begin go = din_ready; kind = CK_DATA; obyte = din_byte; end
      S_JCMD:  begin go = !pend_q; obyte = OP_JUMP; end
      S_JADDR: begin
        go    = !pend_q;
        kind  = CK_ADDR;
        obyte = idx_q[0] ? col_q[15:8] : col_q[7:0];
      end
      S_CONF:  begin go = !pend_q; obyte = OP_COMMIT; end
      S_SCMD:  begin go = !pend_q; obyte = OP_STATUS; end
      S_SRD:   begin go = !pend_q; kind = CK_READ; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= S_IDLE;
      pend_q        <= 1'b0;
      jtaken_q      <= 1'b0;
      idx_q         <= '0;
      col_q         <= '0;
      left_q        <= '0;
      row_q         <= '0;
      cnt_q         <= '0;
      done_o        <= 1'b0;
      fail_o        <= 1'b0;
      limit_err_o   <= 1'b0;
      timeout_err_o <= 1'b0;
    end else begin
      done_o        <= 1'b0;
      fail_o        <= 1'b0;
      limit_err_o   <= 1'b0;
      timeout_err_o <= 1'b0;
      if (go) pend_q <= 1'b1;
      if (cyc_done) pend_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          row_q   <= req_row;
          col_q   <= req_col;
          left_q  <= req_len;
          state_q <= S_CHECK;
        end
        S_CHECK: if (allow) state_q <= S_SETUP;
                 else begin limit_err_o <= 1'b1; state_q <= S_IDLE; end
        S_SETUP: if (cyc_done) begin idx_q <= '0; state_q <= S_ADDR; end
        S_ADDR: if (cyc_done) begin
          if (idx_q == 3'(ADDR_CYC - 1)) state_q <= S_DATA;
          else idx_q <= idx_q + 1'b1;
        end
        S_DATA: begin
          if (!pend_q && din_valid && want_jump) begin
            col_q    <= din_col;
            jtaken_q <= 1'b1;
            state_q  <= S_JCMD;
          end
          if (go) begin
            jtaken_q <= 1'b0;
            left_q   <= left_q - 1'b1;
          end
          if (cyc_done && left_q == 16'd0) state_q <= S_CONF;
        end
        S_JCMD: if (cyc_done) begin idx_q <= '0; state_q <= S_JADDR; end
        S_JADDR: if (cyc_done) begin
          if (idx_q[0]) state_q <= S_DATA;
          else idx_q <= idx_q + 1'b1;
        end
        S_CONF: if (cyc_done) begin cnt_q <= '0; state_q <= S_GAP; end
        S_GAP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q >= CNT_W'(BUSY_GAP - 1)) begin cnt_q <= '0; state_q <= S_WAIT; end
        end
        S_WAIT: begin
          if (nand_rb) state_q <= S_SCMD;
          else if (cnt_q == CNT_W'(TIMEOUT - 1)) begin
            timeout_err_o <= 1'b1;
            state_q       <= S_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_SCMD: if (cyc_done) state_q <= S_SRD;
        S_SRD: if (cyc_done) begin
          done_o  <= 1'b1;
          fail_o  <= rd_byte[0];
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  nand_bus_strobe #(.HOLD(STROBE_W)) i_strobe (
    .clk(clk), .rst_n(rst_n), .start(go), .kind_i(kind), .byte_i(obyte),
    .io_in(nand_io_in), .done(cyc_done), .rd_byte(rd_byte),
    .we_n(nand_we_n), .re_n(nand_re_n), .cle(nand_cle), .ale(nand_ale),
    .io_out(nand_io_out), .io_oe(nand_io_oe)
  );

  nand_page_tally #(.ROW_W(ROW_W), .IDX_W(TALLY_IDX), .LIMIT(PP_LIMIT)) i_tally (
    .clk(clk), .rst_n(rst_n), .row(row_q), .allow(allow),
    .bump(go && state_q == S_CONF)
  );

  // R6
  din_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> din_valid);

  // R6
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_ce_n && nand_we_n && nand_re_n));

  // R8
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_WAIT |-> cnt_q < CNT_W'(TIMEOUT));

  // R9
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limit_err_o |-> (nand_ce_n && !done_o && $past(nand_ce_n)));

  // R7
  single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_err_o));
endmodule

// File: tb/test_nand_pgm_seq.sv
`timescale 1ns/1ps
module test_nand_pgm_seq;
  localparam int ACYC = 4;
  localparam int SW   = 2;
  localparam int TO   = 40;

  typedef struct packed {
    logic [15:0] row;
    logic [15:0] col;
    logic [7:0]  len;
    logic [7:0]  jat;
    logic [15:0] jcol;
    logic        gaps;
    logic        sfail;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'h0012, 16'h0000, 8'd4, 8'hFF, 16'h0000, 1'b0, 1'b0},
    '{16'h0A21, 16'h0834, 8'd6, 8'd3,  16'h0100, 1'b1, 1'b0},
    '{16'hFFFF, 16'h083F, 8'd3, 8'd0,  16'h0004, 1'b0, 1'b1},
    '{16'h1234, 16'h0102, 8'd1, 8'hFF, 16'h0000, 1'b1, 1'b1},
    '{16'h0005, 16'h07FE, 8'd5, 8'd4,  16'h0777, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, din_valid = 0, din_jump = 0;
  logic [15:0] req_row = 0, req_col = 0, req_len = 0, din_col = 0;
  logic [7:0] din_byte = 0;
  logic req_ready, din_ready, nand_io_oe, nand_cle, nand_ale, nand_ce_n;
  logic nand_we_n, nand_re_n, nand_rb, done_o, fail_o, limit_err_o, timeout_err_o;
  logic [7:0] nand_io_out, nand_io_in;

  always #2.5 clk = ~clk;

  nand_pgm_seq #(.ADDR_CYC(ACYC), .STROBE_W(SW), .BUSY_GAP(2), .TIMEOUT(TO),
                 .TALLY_IDX(3), .PP_LIMIT(4)) i_nand_pgm_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_len(req_len),
    .din_valid(din_valid), .din_ready(din_ready), .din_byte(din_byte),
    .din_jump(din_jump), .din_col(din_col), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_rb(nand_rb), .done_o(done_o), .fail_o(fail_o),
    .limit_err_o(limit_err_o), .timeout_err_o(timeout_err_o)
  );

  // device model and monitor, sampled on the falling edge
  int busy_len = 12;
  logic [7:0] stat_byte = 8'h40;
  int busy_cnt = 0;
  logic [9:0] log_mem [512];
  int log_n = 0;
  logic we_d = 1, rb_d = 1;
  int cyc = 0, done_cnt = 0, lim_cnt = 0, to_cnt = 0, ce_low = 0;
  int done_cyc = 0, rise_cyc = 0, low_run = 0, low_bad = 0, low_runs = 0, rdy_bad = 0;
  logic last_fail = 0;

  assign nand_rb    = busy_cnt == 0;
  assign nand_io_in = nand_re_n ? 8'h00 : stat_byte;

  always @(negedge clk) begin
    cyc  <= cyc + 1;
    we_d <= nand_we_n;
    rb_d <= nand_rb;
    if (rst_n) begin
      if (!we_d && nand_we_n) begin
        log_mem[log_n[8:0]] <= {nand_cle, nand_ale, nand_io_out};
        log_n <= log_n + 1;
        if (nand_cle && nand_io_out == 8'h10) busy_cnt <= busy_len;
      end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (nand_rb && !rb_d) rise_cyc <= cyc;
      if (done_o) begin done_cnt <= done_cnt + 1; done_cyc <= cyc; last_fail <= fail_o; end
      if (limit_err_o) lim_cnt <= lim_cnt + 1;
      if (timeout_err_o) to_cnt <= to_cnt + 1;
      if (!nand_ce_n) ce_low <= ce_low + 1;
      if (din_ready && !din_valid) rdy_bad <= rdy_bad + 1;
      if (req_ready && !nand_ce_n) rdy_bad <= rdy_bad + 1;
      if (!nand_we_n || !nand_re_n) low_run <= low_run + 1;
      else if (low_run != 0) begin
        low_runs <= low_runs + 1;
        if (low_run != SW) low_bad <= low_bad + 1;
        low_run <= 0;
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input vec_t v, input int i);
    return v.row[7:0] ^ (8'(i) * 8'h1d + 8'h5a);
  endfunction

  task automatic send_req(input vec_t v);
    @(negedge clk);
    req_valid = 1; req_row = v.row; req_col = v.col; req_len = 16'(v.len);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic send_data(input vec_t v);
    for (int i = 0; i < int'(v.len); i++) begin
      @(negedge clk);
      din_valid = 1; din_byte = dbyte(v, i);
      din_jump = (i == int'(v.jat)); din_col = v.jcol;
      #1;
      while (!din_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      din_valid = 0; din_jump = 0;
      if (v.gaps) repeat (2) @(negedge clk);
    end
  endtask

  task automatic run_txn(input vec_t v, input bit expect_to, input string tag);
    logic [9:0] exp [64];
    int n = 0, base, d0, t0;
    exp[n++] = {2'b10, 8'h80};
    exp[n++] = {2'b01, v.col[7:0]};
    exp[n++] = {2'b01, v.col[15:8]};
    for (int r = 0; r < ACYC - 2; r++) exp[n++] = {2'b01, v.row[8*r +: 8]};
    for (int i = 0; i < int'(v.len); i++) begin
      if (i == int'(v.jat)) begin
        exp[n++] = {2'b10, 8'h85};
        exp[n++] = {2'b01, v.jcol[7:0]};
        exp[n++] = {2'b01, v.jcol[15:8]};
      end
      exp[n++] = {2'b00, dbyte(v, i)};
    end
    exp[n++] = {2'b10, 8'h10};
    if (!expect_to) exp[n++] = {2'b10, 8'h70};
    busy_len  = expect_to ? 300 : 12;
    stat_byte = v.sfail ? 8'h41 : 8'h40;
    @(posedge clk);
    base = log_n; d0 = done_cnt; t0 = to_cnt;
    fork
      send_req(v);
      send_data(v);
    join
    for (int w = 0; w < 3000 && done_cnt == d0 && to_cnt == t0; w++) @(posedge clk);
    repeat (4) @(posedge clk);
    // R2 R3 R4: cycle count and every recorded bus cycle
    check(log_n - base == n, {tag, " R2 cycle count"}, log_n - base, n);
    for (int k = 0; k < n && k < log_n - base; k++)
      check(log_mem[(base + k) % 512] == exp[k], {tag, " R2/R3/R4 bus cycle"},
            int'(log_mem[(base + k) % 512]), int'(exp[k]));
    if (expect_to) begin
      check(to_cnt == t0 + 1, {tag, " R8 timeout pulse"}, to_cnt - t0, 1);
      check(done_cnt == d0, {tag, " R8 no done"}, done_cnt - d0, 0);
    end else begin
      check(done_cnt == d0 + 1, {tag, " R7 done pulse"}, done_cnt - d0, 1);
      check(last_fail == v.sfail, {tag, " R7 fail flag"}, int'(last_fail), int'(v.sfail));
      check(done_cyc > rise_cyc, {tag, " R7 done after ready"}, done_cyc, rise_cyc);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t lv;
    int l0, c0, n0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
          "R1 bus idle in reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 5'b11100);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !done_o && !limit_err_o && !timeout_err_o, "R1 after reset",
          {req_ready, done_o, limit_err_o, timeout_err_o}, 4'b1000);

    for (int t = 0; t < 5; t++) run_txn(VECS[t], 1'b0, $sformatf("vec%0d", t));

    // R9: four programs to one row, then a fifth
    lv = '{16'h0033, 16'h0010, 8'd2, 8'hFF, 16'h0000, 1'b0, 1'b0};
    for (int p = 0; p < 4; p++) run_txn(lv, 1'b0, "R9 partial");
    @(posedge clk);
    l0 = lim_cnt; c0 = ce_low; n0 = log_n;
    send_req(lv);
    repeat (10) @(posedge clk);
    check(lim_cnt == l0 + 1, "R9 limit pulse", lim_cnt - l0, 1);
    check(ce_low == c0, "R9 chip enable untouched", ce_low - c0, 0);
    check(log_n == n0, "R9 no bus cycles", log_n - n0, 0);
    run_txn('{16'h0040, 16'h0020, 8'd2, 8'hFF, 16'h0000, 1'b0, 1'b1}, 1'b0, "R9 other row");

    // R8: device stays busy
    run_txn('{16'h0066, 16'h0000, 8'd2, 8'd1, 16'h0300, 1'b0, 1'b0}, 1'b1, "R8 busy");
    for (int w = 0; w < 400 && !nand_rb; w++) @(posedge clk);
    run_txn('{16'h0067, 16'h0001, 8'd3, 8'hFF, 16'h0000, 1'b1, 1'b0}, 1'b0, "R8 recovery");

    // R5 strobe width and R6 handshake rules over the whole run
    check(low_bad == 0 && low_runs > 0, "R5 strobe low width", low_bad, 0);
    check(rdy_bad == 0, "R6 ready rules", rdy_bad, 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule